// File: doc/BRIEF.md
# Hex Response Frame Encoder

This block turns a 16-bit response word into a seven-byte printable frame and hands it, one byte at a time, to a downstream byte transmitter. A frame is the letter 'D', then the word as four uppercase hexadecimal digits with the most significant nibble first and leading zeros kept, then a carriage return and a line feed.

Words arrive on a valid/ready input. The producer holds `in_valid` and `in_word` until it sees `in_ready` high at a rising clock edge. `in_ready` is high only while the encoder is idle and comes from registered state only, so it has no combinational path from `in_valid`. While a frame is in flight, `in_ready` stays low and the input is neither sampled nor stored.

Each output byte is offered on `tx_byte` with a one-cycle `tx_start` pulse. The encoder holds that byte until the transmitter answers with a one-cycle `tx_done`, and only then moves on to the next byte. Bit timing, the line driver and command parsing belong to other blocks.

Top module: `hex_frame_encoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` is 0, `in_ready` is 1 and `tx_start` is 0.
- R2: A word is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `busy` is 1 from the next cycle, and `in_ready` is the inverse of `busy`.
- R3: The first byte of every frame is 0x44 ('D'), and its `tx_start` pulse appears in the cycle right after acceptance.
- R4: Bytes two to five are the four nibbles of the word, most significant first, each encoded as ASCII. Digits 0-9 are sent as 0x30-0x39, and zero nibbles are sent as 0x30.
- R5: Nibble values 10-15 are sent as uppercase letters 0x41-0x46.
- R6: Byte six is 0x0D and byte seven is 0x0A. A frame has exactly seven `tx_start` pulses.
- R7: `tx_start` lasts one cycle per byte. After the first byte, each `tx_start` appears in the cycle right after the `tx_done` that ends the previous byte, and never earlier.
- R8: `tx_byte` keeps its value from its `tx_start` cycle until `tx_done` is seen.
- R9: Changes on `in_word` or `in_valid` while `busy` is 1 do not alter the frame in flight.
- R10: `busy` falls, and `in_ready` rises, in the cycle after the `tx_done` for the line feed. A new word can be accepted in that same cycle.
- R11: `tx_done` has no effect while idle or during a `tx_start` cycle. It produces no pulse and advances no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers `in_word` |
| in_ready | output | 1 | Encoder idle and able to take a word |
| in_word | input | 16 | Response word to encode |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_start | output | 1 | One-cycle pulse: `tx_byte` is new |
| tx_done | input | 1 | One-cycle pulse: transmitter finished the byte |
| busy | output | 1 | A frame is in flight |

## Verification
After an acceptance edge, `busy` and the first `tx_start` are due one cycle later. After a `tx_done` is sampled in a waiting cycle, the next `tx_start` is due one cycle later. After the final `tx_done`, `busy` is due to fall one cycle later. The bench drives inputs on falling edges and samples outputs on the falling edge that follows each rising edge, so every result is read in the exact cycle these latencies predict. While it waits between a byte's start and its done, the bench also checks in every cycle that no early pulse appears and that the byte stays the same.

// File: rtl/hexenc_pkg.sv
package hexenc_pkg;

  typedef enum logic [1:0] {
    ENC_IDLE   = 2'd0,
    ENC_LAUNCH = 2'd1,
    ENC_WAIT   = 2'd2
  } enc_state_e;

  localparam logic [7:0] FRAME_LEAD = 8'h44;
  localparam logic [7:0] FRAME_CR   = 8'h0D;
  localparam logic [7:0] FRAME_LF   = 8'h0A;

  // Nibble to uppercase ASCII hex character.
  function automatic logic [7:0] nib_to_char(input logic [3:0] n);
    logic [7:0] r;
    if (n < 4'd10) r = 8'h30 + {4'd0, n};
    else           r = 8'h37 + {4'd0, n};
    return r;
  endfunction

endpackage

// File: rtl/hexenc_capture.sv
module hexenc_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

endmodule

// File: rtl/hexenc_seq.sv
module hexenc_seq
  import hexenc_pkg::*;
#(
  parameter int FRAME_LEN = 7,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             tx_done,
  output logic             busy,
  output logic             launch,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  enc_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENC_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ENC_IDLE: begin
          if (accept) begin
            state <= ENC_LAUNCH;
            idx   <= '0;
          end
        end
        ENC_LAUNCH: state <= ENC_WAIT;
        ENC_WAIT: begin
          if (tx_done) begin
            if (idx == LAST_IDX) begin
              state <= ENC_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ENC_LAUNCH;
            end
          end
        end
        default: state <= ENC_IDLE;
      endcase
    end
  end

  assign busy   = (state != ENC_IDLE);
  assign launch = (state == ENC_LAUNCH);

endmodule

// File: rtl/hexenc_byte_mux.sv
module hexenc_byte_mux
  import hexenc_pkg::*;
#(
  parameter int DATA_W    = 16,
  localparam int NIB      = DATA_W / 4,
  localparam int FRAME_LEN = NIB + 3,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  output logic [7:0]        byte_o
);

  logic [7:0] chars [NIB];

  for (genvar gi = 0; gi < NIB; gi++) begin : g_char
    assign chars[gi] = nib_to_char(word[DATA_W-1-4*gi -: 4]);
  end

  always_comb begin
    byte_o = FRAME_LF;
    if (idx == '0) byte_o = FRAME_LEAD;
    for (int k = 0; k < NIB; k++) begin
      if (idx == IDX_W'(k + 1)) byte_o = chars[k];
    end
    if (idx == IDX_W'(NIB + 1)) byte_o = FRAME_CR;
  end

endmodule

// File: rtl/hex_frame_encoder.sv
module hex_frame_encoder #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_word,
  output logic [7:0]        tx_byte,
  output logic              tx_start,
  input  logic              tx_done,
  output logic              busy
);

  localparam int NIB       = DATA_W / 4;
  localparam int FRAME_LEN = NIB + 3;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  logic              accept;
  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  idx;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  hexenc_capture #(.DATA_W(DATA_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .word_in(in_word),
    .word_q (word_q)
  );

  hexenc_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .tx_done(tx_done),
    .busy   (busy),
    .launch (tx_start),
    .idx    (idx)
  );

  hexenc_byte_mux #(.DATA_W(DATA_W)) u_mux (
    .word  (word_q),
    .idx   (idx),
    .byte_o(tx_byte)
  );

endmodule

// File: rtl/hexenc_checker.sv
module hexenc_checker #(
  parameter int FRAME_LEN = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] tx_byte,
  input logic       tx_start,
  input logic       tx_done,
  input logic       busy
);

  localparam int CW = $clog2(FRAME_LEN + 1) + 1;

  logic          pending;
  logic [CW-1:0] starts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      starts  <= '0;
    end else begin
      if (tx_start)     pending <= 1'b1;
      else if (tx_done) pending <= 1'b0;
      if (in_valid && in_ready) starts <= '0;
      else if (tx_start)        starts <= starts + 1'b1;
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  assert_lead_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_start && tx_byte == 8'h44));

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (starts == CW'(FRAME_LEN)));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  assert_no_early_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !tx_done) |-> !tx_start);

  assert_byte_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start || (pending && !tx_done)) |=> $stable(tx_byte));

endmodule

bind hex_frame_encoder hexenc_checker #(.FRAME_LEN(DATA_W / 4 + 3)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .tx_byte (tx_byte),
  .tx_start(tx_start),
  .tx_done (tx_done),
  .busy    (busy)
);

// File: tb/hex_frame_encoder_test.sv
module hex_frame_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  localparam logic [15:0] VEC_WORD [NVEC] = '{
    16'h0000, 16'h1234, 16'hBABE, 16'hFFFF,
    16'h00A5, 16'h9ABC, 16'h5678, 16'hF00F
  };
  localparam logic [55:0] VEC_FRAME [NVEC] = '{
    {"D0000", 8'h0D, 8'h0A}, {"D1234", 8'h0D, 8'h0A},
    {"DBABE", 8'h0D, 8'h0A}, {"DFFFF", 8'h0D, 8'h0A},
    {"D00A5", 8'h0D, 8'h0A}, {"D9ABC", 8'h0D, 8'h0A},
    {"D5678", 8'h0D, 8'h0A}, {"DF00F", 8'h0D, 8'h0A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [7:0]  tx_byte;
  logic        tx_start;
  logic        tx_done = 1'b0;
  logic        busy;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hex_frame_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .tx_byte(tx_byte), .tx_start(tx_start),
    .tx_done(tx_done), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Send one word, act as transmitter with 'lat' wait cycles per byte.
  task automatic run_frame(input logic [15:0] w, input logic [55:0] exp,
                           input int lat, input bit scramble, input bit early);
    logic [7:0] cap;
    logic [7:0] eb;
    string tag;
    in_word  = w;
    in_valid = 1'b1;
    check(in_ready == 1'b1, "R2 ready before accept", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    check(in_ready == 1'b0, "R2 ready low while busy", int'(in_ready), 0);
    if (scramble) begin
      // R9: new offers while busy must not leak into the frame
      in_word  = ~w;
      in_valid = 1'b1;
    end
    for (int b = 0; b < 7; b++) begin
      eb = exp[55-8*b -: 8];
      if (b == 0)               tag = "R3";
      else if (b >= 5)          tag = "R6";
      else if (eb >= 8'h41)     tag = "R5";
      else                      tag = "R4";
      if (scramble) tag = {tag, " R9"};
      check(tx_start == 1'b1, {tag, " R7 start"}, int'(tx_start), 1);
      check(tx_byte == eb, tag, int'(tx_byte), int'(eb));
      cap = tx_byte;
      if (early && b == 1) begin
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check(!tx_start && tx_byte == cap, "R11 done in start cycle",
              int'(tx_byte), int'(cap));
      end
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check(!tx_start && tx_byte == cap, "R8 hold / R7 no early start",
              int'({tx_start, tx_byte}), int'({1'b0, cap}));
      end
      if (b == 6) in_valid = 1'b0;
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
    end
    check(busy == 1'b0, "R10 busy falls", int'(busy), 0);
    check(in_ready == 1'b1, "R10 ready rises", int'(in_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(busy == 1'b0 && in_ready == 1'b1 && tx_start == 1'b0, "R1 in reset",
          int'({busy, in_ready, tx_start}), 3'b010);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && in_ready == 1'b1 && tx_start == 1'b0, "R1 after reset",
          int'({busy, in_ready, tx_start}), 3'b010);

    // R11: stray done pulses while idle
    for (int i = 0; i < 3; i++) begin
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      check(tx_start == 1'b0 && busy == 1'b0, "R11 done while idle",
            int'({tx_start, busy}), 0);
    end

    // Table walk, frames back to back (R10 immediate re-accept)
    for (int v = 0; v < NVEC; v++) begin
      run_frame(VEC_WORD[v], VEC_FRAME[v], 1 + (v % 3), 1'b0, 1'b0);
    end

    // Corner cases
    run_frame(16'hC0DE, {"DC0DE", 8'h0D, 8'h0A}, 2, 1'b1, 1'b0);  // R9
    run_frame(16'h0E0F, {"D0E0F", 8'h0D, 8'h0A}, 1, 1'b0, 1'b1);  // R11
    run_frame(16'h7FFF, {"D7FFF", 8'h0D, 8'h0A}, 5, 1'b1, 1'b1);

    // R10: idle stays idle with no offer
    @(negedge clk);
    check(busy == 1'b0 && tx_start == 1'b0, "R10 idle after frame",
          int'({busy, tx_start}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule